// File: doc/BRIEF.md
# Range Translation Lookaside Buffer

This block is a small fully associative cache of range translations. Each entry describes a run of contiguous virtual pages, of any length, that maps onto an equally long run of contiguous physical pages with a single protection setting. The entry holds a lower bound page, an upper bound page, a page offset and a protection code. When the first-level page TLB misses, the requesting logic presents a 36-bit virtual page number (address bits 47..12, so 4KB pages). In the same cycle, the second-level page TLB is searched in parallel with this block. Every entry compares the page number against its own bounds at once.

On a hit, the block returns a complete 4KB refill for the first-level TLB. The physical page is the virtual page plus the entry's offset, and the entry's protection comes with it. Ranges are loaded through a fill port. A lookup page can be used to drop the ranges that contain it, and a flush empties the whole buffer. Operating-system range tables, the walker and the page TLBs are outside this block.

Top module: `range_tlb`

## Requirements
- R1: After reset no entry is valid. rsp_valid and rsp_hit are 0, and any lookup misses.
- R2: An entry hits only when it is valid and base <= vpn < limit, which includes base and excludes limit. An entry with limit <= base never hits.
- R3: On a hit, rsp_ppn equals vpn + offset kept to the low 36 bits, and rsp_prot equals the entry's protection code.
- R4: The response is registered one cycle after the request. rsp_valid is high in the cycle after lk_valid was high and low otherwise. On a miss, rsp_ppn and rsp_prot are zero.
- R5: When several valid entries hit, the entry with the lowest index supplies the response.
- R6: A fill writes into the lowest-index invalid entry when one exists. The round-robin pointer does not move in that case.
- R7: When every entry is valid, a fill replaces the entry selected by a round-robin pointer. The pointer starts at index 0 after reset, advances by one with each replacing fill, and wraps from the last index to 0.
- R8: An invalidate clears every valid entry whose range contains inv_vpn and leaves all other entries unchanged.
- R9: A flush clears every entry in one cycle.
- R10: A flush in the same cycle as a fill or an invalidate wins, and the fill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 36 | Virtual page number to translate |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | A range covered the page |
| rsp_ppn | output | 36 | Physical page number for the refill |
| rsp_prot | output | 4 | Protection code for the refill |
| fill_en | input | 1 | Load a new range |
| fill_base | input | 36 | First virtual page of the range |
| fill_limit | input | 36 | Virtual page just past the range |
| fill_offset | input | 36 | Amount added to the virtual page |
| fill_prot | input | 4 | Protection code of the range |
| inv_en | input | 1 | Invalidate ranges containing inv_vpn |
| inv_vpn | input | 36 | Page used for the invalidate |
| flush | input | 1 | Clear every entry |

## Verification
The bench builds the block with NUM_ENTRIES set to 4 and keeps the default 36-bit page width and 4-bit protection width. With four entries, the bench can fill the buffer with a handful of writes. It can then walk the round-robin pointer through every index and past its wrap point, and it can bring free-slot reuse after an invalidate within reach. The full page width lets one range sit at the top of the address space, so the offset addition overflows and the truncation rule can be checked at the outputs.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

    parameter int VPN_W  = 36;
    parameter int PROT_W = 4;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PROT_W-1:0] prot_t;

    typedef struct packed {
        logic  valid;
        vpn_t  lo;
        vpn_t  hi;
        vpn_t  delta;
        prot_t prot;
    } rng_ent_t;

    typedef struct packed {
        logic  hit;
        vpn_t  ppn;
        prot_t prot;
    } rng_rsp_t;

    function automatic logic covers(input vpn_t page, input vpn_t lo, input vpn_t hi);
        return (page >= lo) && (page < hi);
    endfunction

endpackage

// File: rtl/range_tlb_match.sv
module range_tlb_match
    import range_tlb_pkg::*;
#(
    parameter int N = 32
) (
    input  rng_ent_t [N-1:0] ents,
    input  vpn_t             page,
    output logic [N-1:0]     hits
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = ents[g].valid && covers(page, ents[g].lo, ents[g].hi);
    end

endmodule

// File: rtl/range_tlb_first.sv
module range_tlb_first #(
    parameter int N     = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        // R5: the chosen index must be a requesting one, with none below it
        if (found) begin
            a_pick_lowest_r5: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
    end

endmodule

// File: rtl/range_tlb.sv
module range_tlb
    import range_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [VPN_W-1:0]  rsp_ppn,
    output logic [PROT_W-1:0] rsp_prot,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_base,
    input  logic [VPN_W-1:0]  fill_limit,
    input  logic [VPN_W-1:0]  fill_offset,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    rng_ent_t [NUM_ENTRIES-1:0] ents;
    logic [NUM_ENTRIES-1:0]     valid_vec;
    logic [NUM_ENTRIES-1:0]     lk_hits;
    logic [NUM_ENTRIES-1:0]     inv_hits;
    logic                       lk_found;
    logic [IDX_W-1:0]           lk_idx;
    logic                       free_found;
    logic [IDX_W-1:0]           free_idx;
    logic [IDX_W-1:0]           rr_ptr;
    logic [IDX_W-1:0]           fill_idx;
    rng_rsp_t                   rsp_q;
    logic                       rsp_v_q;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vld
        assign valid_vec[g] = ents[g].valid;
    end

    range_tlb_match #(.N(NUM_ENTRIES)) u_lk_match (
        .ents(ents), .page(lk_vpn), .hits(lk_hits)
    );

    range_tlb_match #(.N(NUM_ENTRIES)) u_inv_match (
        .ents(ents), .page(inv_vpn), .hits(inv_hits)
    );

    range_tlb_first #(.N(NUM_ENTRIES)) u_hit_sel (
        .req(lk_hits), .found(lk_found), .idx(lk_idx)
    );

    range_tlb_first #(.N(NUM_ENTRIES)) u_free_sel (
        .req(~valid_vec), .found(free_found), .idx(free_idx)
    );

    assign fill_idx = free_found ? free_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ents    <= '0;
            rr_ptr  <= '0;
            rsp_q   <= '0;
            rsp_v_q <= 1'b0;
        end else begin
            rsp_v_q <= lk_valid;
            if (lk_valid && lk_found) begin
                rsp_q.hit  <= 1'b1;
                rsp_q.ppn  <= lk_vpn + ents[lk_idx].delta;
                rsp_q.prot <= ents[lk_idx].prot;
            end else begin
                rsp_q <= '0;
            end

            if (flush) begin
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    ents[i].valid <= 1'b0;
                end
            end else begin
                if (inv_en) begin
                    for (int i = 0; i < NUM_ENTRIES; i++) begin
                        if (inv_hits[i]) ents[i].valid <= 1'b0;
                    end
                end
                if (fill_en) begin
                    ents[fill_idx] <= '{valid: 1'b1, lo: fill_base, hi: fill_limit,
                                        delta: fill_offset, prot: fill_prot};
                    if (!free_found) begin
                        rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
                    end
                end
            end
        end
    end

    assign rsp_valid = rsp_v_q;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_ppn   = rsp_q.ppn;
    assign rsp_prot  = rsp_q.prot;

    p_req_resp_r4: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    p_idle_resp_r4: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_ppn == '0 && rsp_prot == '0));

    p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_found |=> !rsp_hit);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    p_fill_grows_r6: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush && !inv_en && free_found)
        |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1 && $stable(rr_ptr)));

    p_rr_moves_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush && !free_found) |=> (rr_ptr != $past(rr_ptr)));

endmodule

// File: tb/range_tlb_tb.sv
module range_tlb_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_vpn = '0;
    logic        rsp_valid, rsp_hit;
    logic [35:0] rsp_ppn;
    logic [3:0]  rsp_prot;
    logic        fill_en = 1'b0;
    logic [35:0] fill_base = '0, fill_limit = '0, fill_offset = '0;
    logic [3:0]  fill_prot = '0;
    logic        inv_en = 1'b0;
    logic [35:0] inv_vpn = '0;
    logic        flush = 1'b0;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    range_tlb #(.NUM_ENTRIES(NE)) u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_prot(rsp_prot),
        .fill_en(fill_en), .fill_base(fill_base), .fill_limit(fill_limit),
        .fill_offset(fill_offset), .fill_prot(fill_prot),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush(flush)
    );

    typedef struct packed {
        logic [35:0] vpn;
        logic        hit;
        logic [35:0] ppn;
        logic [3:0]  prot;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{36'h0FF,        1'b0, 36'h0,     4'd0, 8'd2},  // R2 below every range
        '{36'h100,        1'b1, 36'h1100,  4'd1, 8'd2},  // R2 base included
        '{36'h1FF,        1'b1, 36'h11FF,  4'd1, 8'd5},  // R5 overlap, index 0 wins
        '{36'h200,        1'b1, 36'h5200,  4'd2, 8'd2},  // R2 limit of entry 0 excluded
        '{36'h2FF,        1'b1, 36'h52FF,  4'd2, 8'd3},  // R3 offset add
        '{36'h300,        1'b0, 36'h0,     4'd0, 8'd2},  // R2 limit of entry 1 excluded
        '{36'hF_FFFF_FF80, 1'b1, 36'h180,  4'd3, 8'd3},  // R3 sum truncated to 36 bits
        '{36'hF_FFFF_FFFF, 1'b0, 36'h0,    4'd0, 8'd2},  // R2 top page equals limit
        '{36'h400,        1'b0, 36'h0,     4'd0, 8'd2}   // R2 empty range never hits
    };

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic look(input string tag, input logic [35:0] vpn, input logic ehit,
                        input logic [35:0] eppn, input logic [3:0] eprot);
        @(negedge clk);
        chk(tag, "valid before request", {63'd0, rsp_valid}, 64'd0);
        lk_valid = 1'b1;
        lk_vpn   = vpn;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(tag, "valid", {63'd0, rsp_valid}, 64'd1);
        chk(tag, "hit", {63'd0, rsp_hit}, {63'd0, ehit});
        chk(tag, "ppn", {28'd0, rsp_ppn}, {28'd0, eppn});
        chk(tag, "prot", {60'd0, rsp_prot}, {60'd0, eprot});
    endtask

    task automatic do_fill(input logic [35:0] b, input logic [35:0] l,
                           input logic [35:0] o, input logic [3:0] p);
        @(negedge clk);
        fill_en = 1'b1; fill_base = b; fill_limit = l; fill_offset = o; fill_prot = p;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_inv(input logic [35:0] v);
        @(negedge clk);
        inv_en = 1'b1; inv_vpn = v;
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "rsp_hit after reset", {63'd0, rsp_hit}, 64'd0);
        look("R1", 36'h100, 1'b0, 36'h0, 4'd0);

        // load all four entries: slots 0..3
        do_fill(36'h100, 36'h200, 36'h1000, 4'd1);
        do_fill(36'h180, 36'h300, 36'h5000, 4'd2);
        do_fill(36'hF_FFFF_FF00, 36'hF_FFFF_FFFF, 36'h200, 4'd3);
        do_fill(36'h400, 36'h400, 36'h0, 4'd4);

        for (int i = 0; i < 9; i++) begin
            look($sformatf("R%0d", VECS[i].req), VECS[i].vpn, VECS[i].hit, VECS[i].ppn, VECS[i].prot);
        end

        // R7 full: replacements go to slot 0, 1, 2, 3 then wrap to 0
        do_fill(36'h800, 36'h900, 36'h0, 4'd5);           // slot 0
        look("R7", 36'h100, 1'b0, 36'h0, 4'd0);
        look("R7", 36'h180, 1'b1, 36'h5180, 4'd2);
        do_fill(36'h180, 36'h190, 36'h7000, 4'd6);        // slot 1
        look("R7", 36'h180, 1'b1, 36'h7180, 4'd6);
        look("R7", 36'h200, 1'b0, 36'h0, 4'd0);
        do_fill(36'hA00, 36'hB00, 36'h0, 4'd7);           // slot 2
        do_fill(36'hA00, 36'hB00, 36'h100, 4'd8);         // slot 3
        look("R7", 36'hA00, 1'b1, 36'hA00, 4'd7);
        do_fill(36'h800, 36'h900, 36'h10, 4'd9);          // wraps to slot 0
        look("R7", 36'h800, 1'b1, 36'h810, 4'd9);

        // R8 invalidate clears both containing entries only
        do_inv(36'hA80);
        look("R8", 36'hA80, 1'b0, 36'h0, 4'd0);
        look("R8", 36'h800, 1'b1, 36'h810, 4'd9);
        look("R8", 36'h185, 1'b1, 36'h7185, 4'd6);

        // R6 fills reuse free slots 2 then 3, pointer untouched
        do_fill(36'hC00, 36'hD00, 36'h0, 4'd10);
        do_fill(36'hC00, 36'hD00, 36'h0, 4'd11);
        look("R6", 36'hC00, 1'b1, 36'hC00, 4'd10);
        look("R6", 36'h180, 1'b1, 36'h7180, 4'd6);
        // next replacement must land on slot 1 (pointer still there)
        do_fill(36'hE00, 36'hE10, 36'h0, 4'd12);
        look("R6", 36'h180, 1'b0, 36'h0, 4'd0);
        look("R6", 36'h800, 1'b1, 36'h810, 4'd9);

        // R9 flush
        do_flush();
        look("R9", 36'h800, 1'b0, 36'h0, 4'd0);
        look("R9", 36'hC00, 1'b0, 36'h0, 4'd0);
        look("R9", 36'hE00, 1'b0, 36'h0, 4'd0);

        // R10 flush beats a fill in the same cycle
        @(negedge clk);
        fill_en = 1'b1; fill_base = 36'h20; fill_limit = 36'h40; fill_offset = 36'h1; fill_prot = 4'd3;
        flush = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
        look("R10", 36'h30, 1'b0, 36'h0, 4'd0);
        do_fill(36'h20, 36'h40, 36'h1, 4'd3);
        look("R10", 36'h30, 1'b1, 36'h31, 4'd3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule